// File: doc/BRIEF.md
# Multiplexed Minimum-Mode Bus Controller

This block runs the external bus cycles of a 16-bit processor core. The external bus has 20 address bits. The low 16 address bits share one set of pins with the data. The top four address bits share pins with status. The core hands over one transfer at a time: a 20-bit address, write data, an upper-byte flag, a memory-or-port flag and a read/write flag. The controller then steps through a fixed four-state cycle, T1 to T4. It places the address and pulses the latch strobe in T1. It turns the shared pins over to status and data afterwards. It stretches the cycle with wait states while the addressed device holds its ready line low.

Between cycles the controller can give the bus to another master. When the request line is high, the controller acknowledges it and drops its output enables. It takes the bus back one clock after the request is withdrawn. The lowest address bit selects the lower data byte. The active-low upper-byte enable selects the upper byte.

Top module: `mux_bus_ctrl`

## Requirements
- R1: In T1, the cycle after a request is accepted, `ale` is high for exactly that one cycle. In that cycle `ad_oe` is high, `ad_out` carries address bits 15..0, `ahs_out` carries address bits 19..16 and `bhe_n` is the inverse of the upper-byte flag.
- R2: From T2 through T4, `ahs_out` carries the status nibble {0, 0, write flag, memory flag}, with the memory flag in bit 0. `bhe_n` reads 1 as status bit S7 during these states.
- R3: From T1 through T4, `mio` is high for a memory transfer and low for a port transfer. Over the same span, `dtr` is high for a write and low for a read.
- R4: In a read, `rd_n` and `den_n` are low from T2 through the last wait state, and `ad_oe` is low after T1. The data on `ad_in` is sampled at the clock edge that ends the cycle's last T3 or wait state. It appears on `rsp_rdata` with `rsp_valid` high during T4.
- R5: In a write, `wr_n` is low from T2 through the last wait state. `ad_oe` stays high with `ad_out` equal to the write data from T2 through T4. `rd_n` and `wr_n` are never low together.
- R6: `ready` low at the clock edge that ends T3 or a wait state inserts a further wait state, and the strobes stay low through it. A cycle therefore lasts 4+N clocks for N wait states, and both strobes are high in T4.
- R7: `req_ready` is high only when the controller is idle, `hold` is low and `rst` is low. A request accepted on a clock edge starts T1 on the next cycle.
- R8: `hold` is honoured only between cycles. A cycle under way runs to the end of T4. `hlda` then rises on the next clock. While `hlda` is high, `bus_en`, `ad_oe` and `req_ready` are low.
- R9: `hlda` falls at the first clock edge at which `hold` is sampled low.
- R10: `rst` high returns the controller to idle at the next clock edge and aborts any cycle under way. After that edge, `rd_n`, `wr_n` and `den_n` are high, and `ale`, `hlda` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Controller accepts the transfer this cycle |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_hi | input | 1 | Upper data byte takes part |
| req_mem | input | 1 | 1 memory, 0 port |
| req_write | input | 1 | 1 write, 0 read |
| rsp_valid | output | 1 | Cycle in T4; read data valid |
| rsp_rdata | output | 16 | Read data |
| ad_out | output | 16 | Multiplexed address/data, outgoing |
| ad_in | input | 16 | Multiplexed address/data, incoming |
| ad_oe | output | 1 | Drive enable for ad_out |
| ahs_out | output | 4 | High address, then status |
| bhe_n | output | 1 | Upper byte enable (active low), then S7 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | Memory (1) or port (0) |
| dtr | output | 1 | Transceiver direction, 1 = outgoing |
| den_n | output | 1 | Transceiver enable, active low |
| bus_en | output | 1 | Enable for strobes, status and address pins |
| ready | input | 1 | Device ready, active high |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus released to the other master |

## Verification
The assertions assume that `ready`, `hold` and the request fields change only away from the rising clock edge. They also assume that the request fields stay stable while `req_valid` is high. The bench meets these assumptions by driving every input on the falling edge. The assertions further assume that the device does not withdraw `ready` between T2 and T3, which only matters through the edge that ends T3. The bench settles `ready` in T1 and raises it only inside the final wait state. It keeps `rst` high for more than four clocks whenever it resets the block.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_hi,
  input  logic          req_mem,
  input  logic          req_write,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] ad_out,
  input  logic [DW-1:0] ad_in,
  output logic          ad_oe,
  output logic [AW-DW-1:0] ahs_out,
  output logic          bhe_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          dtr,
  output logic          den_n,
  output logic          bus_en,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);

  localparam int HW = AW - DW;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HLD
  } st_t;

  st_t st, st_nx;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic          c_hi, c_mem, c_wr;
  logic [DW-1:0] rdata_q;

  logic in_data, in_strb, in_cyc, take, rd_done;

  assign in_strb = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign in_data = in_strb || (st == S_T4);
  assign in_cyc  = in_data || (st == S_T1);
  assign req_ready = (st == S_IDLE) && !hold && !rst;
  assign take    = req_valid && req_ready;
  assign rd_done = ((st == S_T3) || (st == S_TW)) && ready && !c_wr;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (hold) st_nx = S_HLD; else if (req_valid) st_nx = S_T1;
      S_T1:   st_nx = S_T2;
      S_T2:   st_nx = S_T3;
      S_T3:   st_nx = ready ? S_T4 : S_TW;
      S_TW:   st_nx = ready ? S_T4 : S_TW;
      S_T4:   st_nx = hold ? S_HLD : S_IDLE;
      S_HLD:  st_nx = hold ? S_HLD : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      c_addr  <= req_addr;
      c_wdata <= req_wdata;
      c_hi    <= req_hi;
      c_mem   <= req_mem;
      c_wr    <= req_write;
    end
    if (rd_done) rdata_q <= ad_in;
  end

  assign rsp_valid = (st == S_T4);
  assign rsp_rdata = rdata_q;

  assign ad_out  = (st == S_T1) ? c_addr[DW-1:0] : c_wdata;
  assign ad_oe   = (st == S_T1) || (in_data && c_wr);
  assign ahs_out = (st == S_T1) ? c_addr[AW-1:DW] :
                   in_data ? {{(HW-2){1'b0}}, c_wr, c_mem} : '0;
  assign bhe_n   = (st == S_T1) ? ~c_hi : 1'b1;
  assign ale     = (st == S_T1);
  assign rd_n    = ~(in_strb && !c_wr);
  assign wr_n    = ~(in_strb && c_wr);
  assign den_n   = ~in_strb;
  assign mio     = in_cyc ? c_mem : 1'b0;
  assign dtr     = in_cyc ? c_wr : 1'b1;
  assign hlda    = (st == S_HLD);
  assign bus_en  = !hlda;

  // R1
  ale_pulse_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  // R1
  ale_drive_chk: assert property (@(posedge clk) disable iff (rst) ale |-> ad_oe && bus_en);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
  // R5
  wr_data_chk: assert property (@(posedge clk) disable iff (rst) !wr_n |-> ad_oe);
  // R4
  rd_float_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe && !den_n);
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) && !ready |=> (!rd_n || !wr_n));
  // R8
  hlda_float_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> !bus_en && !ad_oe && !req_ready);
  // R8
  hold_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |=> !hlda);
  // R9
  hlda_drop_chk: assert property (@(posedge clk) disable iff (rst) hlda && !hold |=> !hlda);

endmodule

// File: tb/mux_bus_ctrl_test.sv
`timescale 1ns/1ps
module mux_bus_ctrl_test;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready, req_hi = 0, req_mem = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, rsp_rdata, ad_out, ad_in = '0;
  logic rsp_valid, ad_oe, bhe_n, ale, rd_n, wr_n, mio, dtr, den_n, bus_en, hlda;
  logic [3:0] ahs_out;
  logic ready = 1, hold = 0;
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] mem_m [64];
  logic [15:0] io_m [64];
  logic [19:0] lat;

  always #2 clk = ~clk;

  mux_bus_ctrl uut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_hi(req_hi), .req_mem(req_mem),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ad_out(ad_out),
    .ad_in(ad_in), .ad_oe(ad_oe), .ahs_out(ahs_out), .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .mio(mio), .dtr(dtr), .den_n(den_n), .bus_en(bus_en), .ready(ready),
    .hold(hold), .hlda(hlda));

  // {mem, write, hi, waits[2:0], addr[19:0], wdata[15:0]}
  localparam logic [41:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 3'd0, 20'h51234, 16'hBEEF},
    {1'b1, 1'b0, 1'b1, 3'd2, 20'h51234, 16'h0000},
    {1'b0, 1'b1, 1'b0, 3'd1, 20'h00040, 16'h12AB},
    {1'b0, 1'b0, 1'b1, 3'd0, 20'h00040, 16'h0000},
    {1'b1, 1'b1, 1'b1, 3'd0, 20'hFFFFF, 16'h7700},
    {1'b1, 1'b0, 1'b1, 3'd3, 20'hFFFFE, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd0, 20'h000F2, 16'h0F0F},
    {1'b1, 1'b0, 1'b1, 3'd1, 20'hA5556, 16'h0000}
  };

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic m, input logic w, input logic hi, input logic [19:0] a,
                      input logic [15:0] wd, input int waits, input bit hmid);
    logic [15:0] exp_rd;
    exp_rd = m ? mem_m[a[6:1]] : io_m[a[6:1]];
    chk(req_ready == 1'b1, "R7 idle accept", {31'd0, req_ready}, 1);
    req_valid = 1; req_addr = a; req_wdata = wd; req_hi = hi; req_mem = m; req_write = w;
    ready = (waits == 0);
    @(negedge clk);
    req_valid = 0;
    chk(ale && ad_oe && ad_out == a[15:0], "R1 T1 address", {15'd0, ale, ad_out}, {15'd1, 1'b1, a[15:0]});
    chk(ahs_out == a[19:16] && bhe_n == ~hi, "R1 T1 high bits", {ahs_out, bhe_n}, {a[19:16], ~hi});
    chk(mio == m && dtr == w, "R3 T1 mio/dtr", {mio, dtr}, {m, w});
    lat = {ahs_out, ad_out};
    @(negedge clk);
    if (hmid) hold = 1;
    chk(!ale && ahs_out == {2'b00, w, m} && bhe_n, "R2 status", {ale, ahs_out, bhe_n}, {1'b0, 2'b00, w, m, 1'b1});
    chk(mio == m && dtr == w, "R3 T2 mio/dtr", {mio, dtr}, {m, w});
    if (w) begin
      chk(!wr_n && rd_n && ad_oe && ad_out == wd, "R5 write data", {wr_n, rd_n, ad_oe, ad_out}, {3'b010, wd});
      if (!lat[0]) begin
        if (m) mem_m[lat[6:1]][7:0] = ad_out[7:0]; else io_m[lat[6:1]][7:0] = ad_out[7:0];
      end
      if (hi) begin
        if (m) mem_m[lat[6:1]][15:8] = ad_out[15:8]; else io_m[lat[6:1]][15:8] = ad_out[15:8];
      end
    end else begin
      chk(!rd_n && wr_n && !ad_oe && !den_n, "R4 read strobe", {rd_n, wr_n, ad_oe, den_n}, 4'b0100);
      ad_in = m ? mem_m[lat[6:1]] : io_m[lat[6:1]];
    end
    @(negedge clk);
    chk(!(rd_n && wr_n) && !den_n, "R6 T3 strobe", {rd_n, wr_n, den_n}, {w, ~w, 1'b0});
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      chk(!(rd_n && wr_n) && !rsp_valid, "R6 wait state", {rd_n, wr_n, rsp_valid}, {w, ~w, 1'b0});
      if (k == waits - 1) ready = 1;
    end
    @(negedge clk);
    chk(rd_n && wr_n && den_n && rsp_valid, "R6 T4 close", {rd_n, wr_n, den_n, rsp_valid}, 4'b1111);
    if (!w) chk(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
    else chk(ad_oe && ad_out == wd, "R5 T4 data held", {ad_oe, ad_out}, {1'b1, wd});
    if (hmid) chk(!hlda, "R8 no grant mid-cycle", hlda, 0);
    ready = 1; ad_in = '0;
    @(negedge clk);
    if (hmid) chk(hlda && !bus_en && !ad_oe, "R8 grant after T4", {hlda, bus_en, ad_oe}, 3'b100);
    else chk(!rsp_valid && req_ready, "R7 back to idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_m[i] = 16'hA000 + 16'(i);
      io_m[i] = 16'h5000 + 16'(i);
    end
    repeat (5) @(negedge clk);
    chk(rd_n && wr_n && den_n && !ale && !hlda && !req_ready, "R10 reset state",
        {rd_n, wr_n, den_n, ale, hlda, req_ready}, 6'b111000);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !ad_oe && bus_en, "R7 idle after reset", {req_ready, ad_oe, bus_en}, 3'b101);

    for (int v = 0; v < 8; v++)
      xfer(VEC[v][41], VEC[v][40], VEC[v][39], VEC[v][35:16], VEC[v][15:0], int'(VEC[v][38:36]), 1'b0);

    // R8 hold in idle
    hold = 1;
    #0.1;
    chk(!req_ready, "R7 hold blocks accept", req_ready, 0);
    req_valid = 1; req_addr = 20'h00010; req_write = 0; req_mem = 1;
    @(negedge clk);
    chk(hlda && !bus_en && !ad_oe, "R8 idle grant", {hlda, bus_en, ad_oe}, 3'b100);
    @(negedge clk);
    chk(hlda && !ale && rd_n, "R8 no cycle during grant", {hlda, ale, rd_n}, 3'b101);
    hold = 0; req_valid = 0;
    @(negedge clk);
    chk(!hlda && req_ready, "R9 release", {hlda, req_ready}, 2'b01);

    // R8 hold raised mid-cycle
    xfer(1'b1, 1'b1, 1'b1, 20'h00100, 16'hC0DE, 1, 1'b1);
    hold = 0;
    @(negedge clk);
    chk(!hlda && bus_en, "R9 release after mid-cycle hold", {hlda, bus_en}, 2'b01);

    // R10 abort
    req_valid = 1; req_addr = 20'h00200; req_write = 0; req_mem = 1; req_hi = 1; ready = 0;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(!rd_n, "R10 read under way", rd_n, 0);
    rst = 1;
    @(negedge clk);
    chk(rd_n && wr_n && den_n && !ale && !hlda && !rsp_valid, "R10 abort",
        {rd_n, wr_n, den_n, ale, hlda, rsp_valid}, 6'b111000);
    repeat (4) @(negedge clk);
    rst = 0; ready = 1;
    @(negedge clk);
    chk(req_ready, "R10 recover", req_ready, 1);
    xfer(1'b1, 1'b0, 1'b1, 20'h00100, 16'h0000, 0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule